// File: doc/BRIEF.md
# Block-Counted SPI Master Engine

This engine moves a counted run of packets across a four-wire serial link as the clocking side. Software programs a control word, a packet count and a status flag through a small word-wide register port. It then launches the run with a start bit. The engine fetches one transmit word per packet from an upstream queue and pushes one received word per packet into a downstream queue. Packet width is programmable from 4 to 32 bits, and bit order is selectable.

The serial clock idles low. Output data changes on the falling edge and input data is sampled on the rising edge. Each clock half lasts a fixed number of system clock cycles, set by a parameter. One of four select lines is chosen for each run, and each line's idle level is programmable. Software can also take direct control of the chosen line, apart from any run. When the last packet is finished, a sticky ready flag is raised, and software clears it by writing a one to it.

Register map on `reg_addr`: 0 is the control word, 1 is the packet count (bits 15:0 hold the number of packets minus one), 2 is status. Reads of any other address return zero.

Top module: `spi_blk_master`

## Requirements
- R1: After reset the control word, packet count and status read as zero, `sclk` and `mosi` are low, all four `cs_o` lines are low, and neither `tx_pop` nor `rx_push` is asserted.
- R2: Control bits 4:0 hold the packet length minus one, so values 3 to 31 give 4 to 32 bits per packet. Values 0 to 2 give 4-bit packets.
- R3: Writing the control word with bit 31 set while idle starts a run. The run moves exactly count+1 packets, producing (count+1) times length rising `sclk` edges, and then stops.
- R4: Status bit 30 sets when the last packet completes. Writing status with bit 30 set clears it. Writing status with bit 30 clear leaves it set. Completion takes priority over a clear in the same cycle.
- R5: Status bits 15:0 give the number of packets completed in the current or last run. They restart from zero at each start.
- R6: With control bit 16 clear, packets are shifted most significant bit first, in both directions. With it set, they are shifted least significant bit first.
- R7: With control bit 11 set, one word is taken from the transmit queue per packet, using `tx_pop`. With bit 11 clear, `mosi` stays low and `tx_pop` never asserts.
- R8: With control bit 12 set, one word is pushed per packet on `rx_push`, with the received bits in the low packet-length bits and zeros above them. With bit 12 clear, nothing is pushed.
- R9: With control bit 21 clear, the line picked by control bits 27:26 is driven to its active level (the inverse of its idle level) while a run is in progress. All other lines stay at their idle levels.
- R10: With control bit 21 set, the picked line follows control bit 20 directly, whether or not a run is in progress.
- R11: Control bits 25:22 give the idle level of lines 3 down to 0. Every line that is not active sits at that level.
- R12: `sclk` is low whenever the engine is idle. Each high phase lasts `HALF_DIV` cycles, and `mosi` holds steady while `sclk` is high.
- R13: If transmit is enabled and the transmit queue is empty when a packet is due, `sclk` stays low until a word arrives. `tx_pop` asserts only when `tx_valid` is high.
- R14: Writes to the control word and to the packet count are ignored while a run is in progress, and this includes the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 count, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Consume the head transmit word this cycle |
| rx_push | output | 1 | Received packet word valid this cycle |
| rx_data | output | 32 | Received packet word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Select lines |

## Verification
The assertions rely on the transmit queue presenting a stable `tx_valid` within each cycle. They also rely on the register port issuing at most one write per cycle. The queue model in the bench therefore updates its read index only on the clock edge, and all register accesses are driven from a single task that spaces them one cycle apart.

The serial device model changes `miso` only after a falling `sclk` edge. This keeps input data inside the mode-0 sampling window, which the received-word checks depend on.

Both the packet-length sweep and the select-line patterns are generated arithmetically. This means every select index and every length code, including the short codes that are promoted to 4 bits, is exercised.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;

  localparam int REG_W    = 32;
  localparam int CNT_W    = 16;
  localparam int NUM_CS   = 4;
  localparam int SEL_W    = 2;
  localparam int LEN_W    = 5;
  localparam int MIN_LM1  = 3;

  // control word field positions (software-visible)
  localparam int START_POS = 31;
  localparam int SEL_POS   = 26;
  localparam int IDLE_POS  = 22;
  localparam int MAN_POS   = 21;
  localparam int MANV_POS  = 20;
  localparam int LSBF_POS  = 16;
  localparam int RXE_POS   = 12;
  localparam int TXE_POS   = 11;
  localparam int LEN_POS   = 0;

  // status word field positions
  localparam int RDY_POS   = 30;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic [SEL_W-1:0]  cs_sel;
    logic [NUM_CS-1:0] cs_idle;
    logic              cs_man;
    logic              cs_man_lvl;
    logic              lsb_first;
    logic              rx_en;
    logic              tx_en;
    logic [LEN_W-1:0]  len_m1;
  } ctrl_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_SHIFT = 2'd2
  } eng_state_t;

  function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.cs_sel     = w[SEL_POS +: SEL_W];
    c.cs_idle    = w[IDLE_POS +: NUM_CS];
    c.cs_man     = w[MAN_POS];
    c.cs_man_lvl = w[MANV_POS];
    c.lsb_first  = w[LSBF_POS];
    c.rx_en      = w[RXE_POS];
    c.tx_en      = w[TXE_POS];
    c.len_m1     = w[LEN_POS +: LEN_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[SEL_POS +: SEL_W]   = c.cs_sel;
    w[IDLE_POS +: NUM_CS] = c.cs_idle;
    w[MAN_POS]            = c.cs_man;
    w[MANV_POS]           = c.cs_man_lvl;
    w[LSBF_POS]           = c.lsb_first;
    w[RXE_POS]            = c.rx_en;
    w[TXE_POS]            = c.tx_en;
    w[LEN_POS +: LEN_W]   = c.len_m1;
    return w;
  endfunction

endpackage

// File: rtl/spi_blk_regs.sv
module spi_blk_regs
  import spi_blk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             busy,
  input  logic             done_pulse,
  input  logic [CNT_W-1:0] pkt_count,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] last_idx,
  output logic             start_pulse,
  output logic             ready
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             rdy_q, rdy_d;
  logic             ctrl_en, last_en;
  logic             wr_ctrl, wr_cnt, wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_cnt  = reg_we && (reg_addr == A_CNT);
  assign wr_stat = reg_we && (reg_addr == A_STAT);

  // configuration is frozen while a run is in flight
  assign ctrl_en     = wr_ctrl && !busy;
  assign last_en     = wr_cnt && !busy;
  assign start_pulse = ctrl_en && reg_wdata[START_POS];

  always_comb begin
    ctrl_d = word_to_ctrl(reg_wdata);
    last_d = reg_wdata[CNT_W-1:0];
    rdy_d  = rdy_q;
    if (done_pulse) begin
      rdy_d = 1'b1;
    end else if (wr_stat && reg_wdata[RDY_POS]) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      last_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (ctrl_en) begin
        ctrl_q <= ctrl_d;
      end
      if (last_en) begin
        last_q <= last_d;
      end
      rdy_q <= rdy_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = ctrl_to_word(ctrl_q);
      A_CNT:  reg_rdata[CNT_W-1:0] = last_q;
      A_STAT: begin
        reg_rdata[RDY_POS]     = rdy_q;
        reg_rdata[CNT_W-1:0]   = pkt_count;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign last_idx = last_q;
  assign ready    = rdy_q;

endmodule

// File: rtl/spi_blk_bitclk.sv
module spi_blk_bitclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic edge_rise,
  output logic edge_fall
);

  localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HC_W-1:0] HC_END = HC_W'(HALF_DIV - 1);

  logic [HC_W-1:0] hcnt_q, hcnt_d;
  logic            sclk_q, sclk_d;
  logic            half_end;

  assign half_end = run && (hcnt_q == HC_END);

  always_comb begin
    hcnt_d = hcnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      hcnt_d = '0;
      sclk_d = 1'b0;
    end else if (half_end) begin
      hcnt_d = '0;
      sclk_d = !sclk_q;
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign edge_rise = half_end && !sclk_q;
  assign edge_fall = half_end && sclk_q;

endmodule

// File: rtl/spi_blk_shifter.sv
module spi_blk_shifter
  import spi_blk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pulse,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] last_idx,
  input  logic             tx_valid,
  input  logic [REG_W-1:0] tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [REG_W-1:0] rx_data,
  input  logic             miso,
  output logic             mosi,
  input  logic             edge_rise,
  input  logic             edge_fall,
  output logic             run,
  output logic             busy,
  output logic             done_pulse,
  output logic [CNT_W-1:0] pkt_count
);

  eng_state_t       st_q, st_d;
  logic [REG_W-1:0] txw_q, txw_d;
  logic [REG_W-1:0] rxw_q, rxw_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] eff_m1;
  logic [LEN_W-1:0] pos;
  logic             last_bit;

  // short length codes are promoted to the minimum packet size
  assign eff_m1   = (ctrl.len_m1 < LEN_W'(MIN_LM1)) ? LEN_W'(MIN_LM1) : ctrl.len_m1;
  assign pos      = ctrl.lsb_first ? idx_q : (eff_m1 - idx_q);
  assign last_bit = (idx_q == eff_m1);

  always_comb begin
    st_d       = st_q;
    txw_d      = txw_q;
    rxw_d      = rxw_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    tx_pop     = 1'b0;
    rx_push    = 1'b0;
    done_pulse = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (start_pulse) begin
          st_d  = ENG_FETCH;
          cnt_d = '0;
        end
      end
      ENG_FETCH: begin
        if (!ctrl.tx_en || tx_valid) begin
          tx_pop = ctrl.tx_en;
          txw_d  = ctrl.tx_en ? tx_data : '0;
          rxw_d  = '0;
          idx_d  = '0;
          st_d   = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        if (edge_rise) begin
          rxw_d[pos] = miso;
        end
        if (edge_fall) begin
          if (last_bit) begin
            cnt_d   = cnt_q + 1'b1;
            rx_push = ctrl.rx_en;
            if (cnt_q == last_idx) begin
              st_d       = ENG_IDLE;
              done_pulse = 1'b1;
            end else begin
              st_d = ENG_FETCH;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      txw_q <= '0;
      rxw_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      txw_q <= txw_d;
      rxw_q <= rxw_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign run       = (st_q == ENG_SHIFT);
  assign busy      = (st_q != ENG_IDLE);
  assign mosi      = run && ctrl.tx_en && txw_q[pos];
  assign rx_data   = rxw_q;
  assign pkt_count = cnt_q;

endmodule

// File: rtl/spi_blk_csdrv.sv
module spi_blk_csdrv
  import spi_blk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs_o
);

  logic [NUM_CS-1:0] cs_q, cs_d;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    logic picked;
    assign picked = (ctrl.cs_sel == SEL_W'(g));
    always_comb begin
      if (!picked) begin
        cs_d[g] = ctrl.cs_idle[g];
      end else if (ctrl.cs_man) begin
        cs_d[g] = ctrl.cs_man_lvl;
      end else begin
        cs_d[g] = busy ? !ctrl.cs_idle[g] : ctrl.cs_idle[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
    end else begin
      cs_q <= cs_d;
    end
  end

  assign cs_o = cs_q;

endmodule

// File: rtl/spi_blk_master.sv
module spi_blk_master
  import spi_blk_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_valid,
  input  logic [31:0] tx_data,
  output logic        tx_pop,
  output logic        rx_push,
  output logic [31:0] rx_data,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] pkt_count;
  logic             start_pulse;
  logic             done_pulse;
  logic             busy;
  logic             run;
  logic             ready;
  logic             edge_rise;
  logic             edge_fall;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  spi_blk_regs regs_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .busy        (busy),
    .done_pulse  (done_pulse),
    .pkt_count   (pkt_count),
    .ctrl        (ctrl),
    .last_idx    (last_idx),
    .start_pulse (start_pulse),
    .ready       (ready)
  );

  spi_blk_bitclk #(.HALF_DIV(HALF_DIV)) bitclk_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .sclk      (sclk),
    .edge_rise (edge_rise),
    .edge_fall (edge_fall)
  );

  spi_blk_shifter shifter_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_pulse (start_pulse),
    .ctrl        (ctrl),
    .last_idx    (last_idx),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_pop      (tx_pop),
    .rx_push     (rx_push),
    .rx_data     (rx_data),
    .miso        (miso),
    .mosi        (mosi),
    .edge_rise   (edge_rise),
    .edge_fall   (edge_fall),
    .run         (run),
    .busy        (busy),
    .done_pulse  (done_pulse),
    .pkt_count   (pkt_count)
  );

  spi_blk_csdrv csdrv_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ctrl  (ctrl),
    .busy  (busy),
    .cs_o  (cs_o)
  );

endmodule

// File: rtl/spi_blk_master_chk.sv
module spi_blk_master_chk
  import spi_blk_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        mosi,
  input logic        tx_pop,
  input logic        tx_valid,
  input logic        rx_push,
  input logic [3:0]  cs_o,
  input logic        busy,
  input logic        ready,
  input ctrl_t       ctrl
);

  // R12: no clock activity outside a run
  p_sclk_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R12: data held through the high phase
  p_mosi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R13: a word is only consumed when present
  p_pop_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);

  // R7: no consumption with transmit disabled
  p_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.tx_en |-> !tx_pop);

  // R8: no pushes with receive disabled
  p_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.rx_en |-> !rx_push);

  // R4: ready only rises as a run ends
  p_ready_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(busy) && !busy));

  // R9: at most one line away from its idle level
  p_one_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_o ^ $past(ctrl.cs_idle)) <= 1);

endmodule

bind spi_blk_master spi_blk_master_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .tx_pop   (tx_pop),
  .tx_valid (tx_valid),
  .rx_push  (rx_push),
  .cs_o     (cs_o),
  .busy     (busy),
  .ready    (ready),
  .ctrl     (ctrl)
);

// File: tb/spi_blk_master_tb.sv
`timescale 1ns/1ps
module spi_blk_master_tb_top;

  localparam int HALF = 2;
  localparam logic [1:0] AD_CTRL = 2'd0;
  localparam logic [1:0] AD_CNT  = 2'd1;
  localparam logic [1:0] AD_STAT = 2'd2;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tx_valid;
  logic [31:0] tx_data;
  logic        tx_pop;
  logic        rx_push;
  logic [31:0] rx_data;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [3:0]  cs_o;

  int n_cmp = 0;
  int n_bad = 0;

  // current run description
  int       cur_len = 8;
  bit       cur_lsb = 0;
  bit       cur_tx  = 1;
  bit       cur_rx  = 1;
  int       gr, gm, n_rise, n_push, n_pop, hi_cnt;
  int       tx_rd, tx_avail;
  bit       fifo_clear, mon_en, prev_sclk, cs_taken;
  logic [3:0]  cs_first;
  logic [31:0] mon_word;
  int       b_i, p_i;

  spi_blk_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  initial clk = 1'b0;
  always #2 clk = !clk;

  function automatic logic [31:0] msk(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  function automatic logic [31:0] tx_pat(input int k, input int len);
    return 32'hC3A5_96E1 ^ (32'(k) * 32'h2F1B_7A4D) ^ {8'(len), 24'h0};
  endfunction

  function automatic logic [31:0] rx_pat(input int k, input int len);
    return 32'h5A3C_0FE1 + (32'(k) * 32'h0137_9BDF) + 32'(len);
  endfunction

  function automatic logic miso_f(input int g, input int len, input bit lsb);
    logic [31:0] w;
    int bb;
    w  = rx_pat(g / len, len);
    bb = g % len;
    return lsb ? w[bb] : w[len - 1 - bb];
  endfunction

  // transmit queue model
  always @(posedge clk) begin
    if (fifo_clear) tx_rd <= 0;
    else if (tx_pop) tx_rd <= tx_rd + 1;
  end
  assign tx_valid = (tx_rd < tx_avail);
  assign tx_data  = tx_pat(tx_rd, cur_len);
  assign miso     = miso_f(gm, cur_len, cur_lsb);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial-side monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (sclk && !prev_sclk) begin
        n_rise++;
        b_i = gr % cur_len;
        p_i = gr / cur_len;
        if (!cs_taken) begin
          cs_first = cs_o;
          cs_taken = 1'b1;
        end
        if (cur_lsb) mon_word[b_i] = mosi;
        else         mon_word[cur_len - 1 - b_i] = mosi;
        if (b_i == cur_len - 1) begin
          if (cur_tx) chk("R6 transmitted packet order", mon_word, tx_pat(p_i, cur_len) & msk(cur_len));
          else        chk("R7 mosi low when transmit off", mon_word, 32'h0);
          mon_word = '0;
        end
        gr++;
      end
      if (!sclk && prev_sclk) begin
        chk("R12 high phase length", 32'(hi_cnt), 32'(HALF));
        gm++;
      end
      hi_cnt = sclk ? hi_cnt + 1 : 0;
      if (rx_push) begin
        chk("R8 received word", rx_data, rx_pat(n_push, cur_len) & msk(cur_len));
        n_push++;
      end
      if (tx_pop) n_pop++;
    end
    prev_sclk = sclk;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = AD_STAT; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input int lm1, input bit lsb, input bit tx,
                                         input bit rx, input int sel, input logic [3:0] idle,
                                         input bit man, input bit lvl);
    logic [31:0] w;
    w = '0;
    w[27:26] = 2'(sel);
    w[25:22] = idle;
    w[21]    = man;
    w[20]    = lvl;
    w[16]    = lsb;
    w[12]    = rx;
    w[11]    = tx;
    w[4:0]   = 5'(lm1);
    return w;
  endfunction

  task automatic wait_ready();
    logic [31:0] v;
    v = '0;
    while (!v[30]) rd(AD_STAT, v);
  endtask

  task automatic run_xfer(input int lm1, input bit lsb, input bit tx, input bit rx,
                          input int last, input int sel, input logic [3:0] idle,
                          input int avail, input bit poke);
    logic [31:0] cw, v;
    logic [3:0]  cs_exp;
    cur_len = (lm1 < 3) ? 4 : lm1 + 1;
    cur_lsb = lsb; cur_tx = tx; cur_rx = rx;
    gr = 0; gm = 0; n_rise = 0; n_push = 0; n_pop = 0; hi_cnt = 0;
    mon_word = '0; cs_taken = 1'b0;
    tx_avail = avail;
    @(negedge clk); fifo_clear = 1'b1;
    @(negedge clk); fifo_clear = 1'b0;
    wr(AD_CNT, 32'(last));
    cw = mk_ctrl(lm1, lsb, tx, rx, sel, idle, 1'b0, 1'b0);
    mon_en = 1'b1;
    wr(AD_CTRL, cw | 32'h8000_0000);
    if (avail < last + 1) begin
      repeat (300) @(negedge clk);
      chk("R13 rises before queue refill", 32'(n_rise), 32'(avail * cur_len));
      chk("R13 sclk held low on empty queue", {31'h0, sclk}, 32'h0);
      tx_avail = 64;
    end
    if (poke) begin
      repeat (10) @(negedge clk);
      wr(AD_CNT, 32'h0);
      wr(AD_CTRL, mk_ctrl(30, !lsb, tx, rx, 3, ~idle, 1'b1, 1'b1) | 32'h8000_0000);
      rd(AD_CTRL, v);
      chk("R14 control unchanged while busy", v, cw);
    end
    wait_ready();
    @(negedge clk);
    chk("R3 rising edge total", 32'(n_rise), 32'((last + 1) * cur_len));
    chk("R2 bits per packet", 32'(n_rise / (last + 1)), 32'(cur_len));
    chk("R7 pops per run", 32'(n_pop), tx ? 32'(last + 1) : 32'h0);
    chk("R8 pushes per run", 32'(n_push), rx ? 32'(last + 1) : 32'h0);
    cs_exp = idle;
    cs_exp[sel] = !idle[sel];
    chk("R9 select active during run", {28'h0, cs_first}, {28'h0, cs_exp});
    chk("R11 select idle after run", {28'h0, cs_o}, {28'h0, idle});
    chk("R12 sclk idle low", {31'h0, sclk}, 32'h0);
    mon_en = 1'b0;
    rd(AD_STAT, v);
    chk("R5 packet count", {16'h0, v[15:0]}, 32'((last + 1) & 16'hFFFF));
    chk("R4 ready set", {31'h0, v[30]}, 32'h1);
    if (poke) begin
      rd(AD_CNT, v);
      chk("R14 count unchanged while busy", v, 32'(last));
    end
    wr(AD_STAT, 32'h0);
    rd(AD_STAT, v);
    chk("R4 zero write keeps ready", {31'h0, v[30]}, 32'h1);
    wr(AD_STAT, 32'h4000_0000);
    rd(AD_STAT, v);
    chk("R4 ready cleared", {31'h0, v[30]}, 32'h0);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = AD_STAT; reg_wdata = '0;
    fifo_clear = 1'b1; mon_en = 1'b0; tx_avail = 0; prev_sclk = 1'b0;
    gm = 0; gr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fifo_clear = 1'b0;

    // R1 reset state
    rd(AD_CTRL, v); chk("R1 control after reset", v, 32'h0);
    rd(AD_CNT, v);  chk("R1 count after reset", v, 32'h0);
    rd(AD_STAT, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 serial pins after reset", {30'h0, sclk, mosi}, 32'h0);
    chk("R1 select lines after reset", {28'h0, cs_o}, 32'h0);
    chk("R1 queue strobes after reset", {30'h0, tx_pop, rx_push}, 32'h0);

    // length codes 0..31, both bit orders
    for (int lm = 0; lm < 32; lm++) begin
      for (int o = 0; o < 2; o++) begin
        run_xfer(lm, o[0], 1'b1, 1'b1, 1, lm % 4, 4'(lm * 5 + o), 64, 1'b0);
      end
    end

    // single direction runs
    run_xfer(7, 1'b0, 1'b1, 1'b0, 4, 1, 4'b0101, 64, 1'b0);
    run_xfer(11, 1'b1, 1'b0, 1'b1, 3, 3, 4'b1010, 64, 1'b0);
    // empty-queue stall
    run_xfer(7, 1'b0, 1'b1, 1'b1, 3, 2, 4'b0000, 2, 1'b0);
    // writes during a run
    run_xfer(7, 1'b1, 1'b1, 1'b1, 3, 0, 4'b1111, 64, 1'b1);
    // longer block
    run_xfer(3, 1'b0, 1'b1, 1'b1, 20, 1, 4'b0010, 64, 1'b0);

    // R10 manual select control
    wr(AD_CTRL, mk_ctrl(7, 1'b0, 1'b0, 1'b0, 2, 4'b0000, 1'b1, 1'b1));
    repeat (2) @(negedge clk);
    chk("R10 manual level high", {28'h0, cs_o}, 32'h4);
    wr(AD_CTRL, mk_ctrl(7, 1'b0, 1'b0, 1'b0, 1, 4'b1111, 1'b1, 1'b0));
    repeat (2) @(negedge clk);
    chk("R10 manual level low", {28'h0, cs_o}, 32'hD);
    wr(AD_CTRL, mk_ctrl(7, 1'b0, 1'b0, 1'b0, 1, 4'b0110, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    chk("R11 idle levels", {28'h0, cs_o}, 32'h6);

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule